// File: doc/BRIEF.md
# Comma-Aligned Serial Word Framer

This block takes a recovered serial bit stream, one bit per accepted clock, and finds where each 10-bit symbol begins. It keeps a 10-bit sliding window over the incoming bits. It watches that window for the comma character in either running disparity: `0011111010` or `1100000101`, with the first-received bit on the left. A comma seen while `reframe_en` is high fixes the symbol boundary. From then on, the block emits one aligned symbol with a one-cycle strobe for every ten accepted bits. When `reframe_en` is low, the boundary stays where it is, even if a comma appears at another bit offset.

Until the first comma has been captured, `frame_pending` stays high. While it is high, no symbol strobe and no ready pulse leave the block, so a receive FIFO downstream never takes misframed bytes. `bypass_mode` does not change the framing at all. It only changes the ready pulse: with `bypass_mode` and `reframe_en` both high, `rdy_pulse` fires only on comma symbols, so there is one pulse per comma received.

The streams flow in one direction only. A bit is taken on every clock where `bit_valid` is high. A symbol is offered on every clock where `sym_valid` is high. A serial line cannot be stalled, so neither side has a ready signal and there is no back-pressure. The consumer must take each symbol in the cycle it is offered. Any gap on the input side, where `bit_valid` is low, simply stretches the time until the next symbol.

Top module: `comma_word_framer`

## Requirements
- R1: While `rst_n` is low, `frame_pending` is 1, and `sym_valid` and `rdy_pulse` are 0.
- R2: While `reframe_en` is high, a comma in either disparity (`0011111010` or `1100000101`, first-received bit in `sym_data[9]`) completing in the window causes the following things in the cycle after its tenth bit is accepted:
  - `sym_valid` is 1;
  - `sym_data` equals the comma;
  - `frame_pending` is 0.
- R3: Once framed, the block strobes `sym_valid` after every tenth accepted bit counted from the boundary. `sym_data` then holds those ten bits, with the earliest bit in bit 9. The block stays framed until reset.
- R4: A clock where `bit_valid` is low neither shifts the window nor advances the bit count. No strobe follows such a clock.
- R5: With `reframe_en` low, a comma at a different bit offset is ignored, and the existing boundary is kept.
- R6: With `reframe_en` low before framing, commas are ignored and `frame_pending` stays 1.
- R7: With `reframe_en` high while framed, a comma at a new offset moves the boundary. The comma is emitted as a symbol, and the next strobe follows ten accepted bits later.
- R8: With `bypass_mode` low, `rdy_pulse` equals `sym_valid`.
- R9: With `bypass_mode` high, the ready pulse depends on `reframe_en`, sampled on the symbol's last bit:
  - if `reframe_en` was high, `rdy_pulse` is 1 only with comma symbols;
  - if `reframe_en` was low, it behaves as in R8.
  - Framing itself is unchanged in bypass.
- R10: While `frame_pending` is 1, `rdy_pulse` and `sym_valid` are 0.
- R11: `sym_is_comma` is 1 exactly when `sym_valid` is 1 and `sym_data` equals either comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | `bit_in` carries a bit this clock |
| bit_in | input | 1 | Serial data bit |
| reframe_en | input | 1 | Allows a comma to set the boundary |
| bypass_mode | input | 1 | Undecoded mode: ready pulses on commas only while `reframe_en` is high |
| sym_data | output | 10 | Aligned symbol, earliest bit in bit 9 |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_is_comma | output | 1 | Current symbol is a comma |
| rdy_pulse | output | 1 | Ready strobe for the downstream FIFO |
| frame_pending | output | 1 | No comma captured yet |

## Verification
A boundary counter that has slipped shows up within one symbol time. A strobe lands at the wrong bit count, and `sym_data` comes out rotated relative to the sent symbols. If the count runs while `bit_valid` is low, the strobe comes early by the length of the gap. A window that reacts to commas while `reframe_en` is low shows up in the cycle after the stray comma's tenth bit: an extra strobe appears carrying the comma. A lock flag that is set wrongly, or a bypass gate that is wrong, shows up directly on `frame_pending` and `rdy_pulse` at the next symbol.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int SYM_W = 10;
  localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;
endpackage

// File: rtl/cmf_window.sv
module cmf_window #(
  parameter int W = cmf_pkg::SYM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] win_next
);
  logic [W-1:0] win_q;

  // newest bit enters at bit 0; earliest of the last W bits sits at W-1
  assign win_next = {win_q[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n)        win_q <= '0;
    else if (shift_en) win_q <= win_next;
  end
endmodule

// File: rtl/cmf_comma_match.sv
module cmf_comma_match #(
  parameter int               W     = cmf_pkg::SYM_W,
  parameter int               N_PAT = 2,
  parameter logic [N_PAT*W-1:0] PATS = {cmf_pkg::COMMA_POS, cmf_pkg::COMMA_NEG}
) (
  input  logic [W-1:0] win,
  output logic         hit
);
  logic [N_PAT-1:0] hits;

  for (genvar gi = 0; gi < N_PAT; gi++) begin : g_pat
    assign hits[gi] = (win == PATS[gi*W +: W]);
  end

  assign hit = |hits;
endmodule

// File: rtl/cmf_boundary.sv
module cmf_boundary #(
  parameter int W = cmf_pkg::SYM_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic reframe_en,
  input  logic comma_hit,
  output logic emit,
  output logic locked
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          locked_q;
  logic          capture;
  logic          at_edge;

  assign capture = bit_valid && reframe_en && comma_hit;
  assign at_edge = bit_valid && locked_q && (cnt_q == LAST);
  assign emit    = capture || at_edge;
  assign locked  = locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (capture) begin
      cnt_q    <= '0;
      locked_q <= 1'b1;
    end else if (bit_valid && locked_q) begin
      cnt_q <= at_edge ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/comma_word_framer.sv
module comma_word_framer #(
  parameter int           W      = cmf_pkg::SYM_W,
  parameter logic [2*W-1:0] COMMAS = {cmf_pkg::COMMA_POS, cmf_pkg::COMMA_NEG}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic         reframe_en,
  input  logic         bypass_mode,
  output logic [W-1:0] sym_data,
  output logic         sym_valid,
  output logic         sym_is_comma,
  output logic         rdy_pulse,
  output logic         frame_pending
);
  logic [W-1:0] win_next;
  logic         comma_hit;
  logic         emit;
  logic         locked;
  logic         comma_only;

  cmf_window #(.W(W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_valid),
    .bit_in   (bit_in),
    .win_next (win_next)
  );

  cmf_comma_match #(.W(W), .N_PAT(2), .PATS(COMMAS)) u_match (
    .win (win_next),
    .hit (comma_hit)
  );

  cmf_boundary #(.W(W)) u_bnd (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .reframe_en (reframe_en),
    .comma_hit  (comma_hit),
    .emit       (emit),
    .locked     (locked)
  );

  // undecoded stream with reframing armed: ready marks commas only
  assign comma_only = bypass_mode && reframe_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_data     <= '0;
      sym_valid    <= 1'b0;
      sym_is_comma <= 1'b0;
      rdy_pulse    <= 1'b0;
    end else begin
      sym_valid    <= emit;
      sym_is_comma <= emit && comma_hit;
      rdy_pulse    <= emit && (!comma_only || comma_hit);
      if (emit) sym_data <= win_next;
    end
  end

  assign frame_pending = !locked;
endmodule

// File: rtl/cmf_checker.sv
module cmf_checker #(
  parameter int W = cmf_pkg::SYM_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_valid,
  input logic         reframe_en,
  input logic         bypass_mode,
  input logic [W-1:0] sym_data,
  input logic         sym_valid,
  input logic         sym_is_comma,
  input logic         rdy_pulse,
  input logic         frame_pending
);
  logic [7:0] bits_since;

  always_ff @(posedge clk) begin
    if (!rst_n)                   bits_since <= '0;
    else if (sym_valid)           bits_since <= bit_valid ? 8'd1 : 8'd0;
    else if (bit_valid && bits_since != 8'hFF) bits_since <= bits_since + 8'd1;
  end

  AST_PENDING_BLOCKS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pending |-> !rdy_pulse); // R10
  AST_VALID_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !frame_pending); // R2
  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(bit_valid)); // R4
  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(frame_pending) |-> !frame_pending); // R3
  AST_BYPASS_RDY_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pulse && $past(bypass_mode && reframe_en) |-> sym_is_comma); // R9
  AST_COMMA_FLAG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    sym_is_comma |-> sym_valid && (sym_data == cmf_pkg::COMMA_NEG || sym_data == cmf_pkg::COMMA_POS)); // R11
  AST_HOLD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !$past(reframe_en) |-> bits_since == 8'(W)); // R5
endmodule

bind comma_word_framer cmf_checker #(.W(W)) u_chk (.*);

// File: tb/comma_word_framer_tb.sv
module comma_word_framer_tb;
  localparam logic [9:0] KN = 10'b0011111010;
  localparam logic [9:0] KP = 10'b1100000101;
  // {reframe_en, bypass_mode, exp_comma, exp_rdy, symbol}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 1'b1, KN},
    {1'b1, 1'b0, 1'b0, 1'b1, 10'h2AA},
    {1'b0, 1'b0, 1'b0, 1'b1, 10'h155},
    {1'b1, 1'b1, 1'b1, 1'b1, KP},
    {1'b1, 1'b1, 1'b0, 1'b0, 10'h266},
    {1'b1, 1'b1, 1'b1, 1'b1, KN},
    {1'b0, 1'b1, 1'b0, 1'b1, 10'h2AA},
    {1'b0, 1'b0, 1'b1, 1'b1, KP}
  };
  localparam logic [19:0] SKEW = {3'b010, KN, 7'b0101010};

  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic reframe_en = 1'b0, bypass_mode = 1'b0;
  logic [9:0] sym_data;
  logic sym_valid, sym_is_comma, rdy_pulse, frame_pending;
  int checks = 0, errors = 0, n_strobe = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  comma_word_framer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .reframe_en(reframe_en), .bypass_mode(bypass_mode), .sym_data(sym_data),
    .sym_valid(sym_valid), .sym_is_comma(sym_is_comma), .rdy_pulse(rdy_pulse),
    .frame_pending(frame_pending)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic send_bit(input logic b);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    if (sym_valid) n_strobe++;
  endtask

  task automatic idle(input int n);
    bit_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sym_valid) n_strobe++;
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk("R1", "pending in reset", frame_pending, 1);
    chk("R1", "valid in reset", sym_valid, 0);
    chk("R1", "rdy in reset", rdy_pulse, 0);
    rst_n = 1'b1;

    // R6: disarmed before framing, comma ignored
    for (int i = 9; i >= 0; i--) send_bit(KN[i]);
    idle(1);
    chk("R6", "strobes before framing", n_strobe, 0);
    chk("R6", "still pending", frame_pending, 1);
    chk("R10", "no rdy while pending", rdy_pulse, 0);

    // table walk: one symbol per entry, with a two-cycle input gap mid-symbol (R4)
    for (int v = 0; v < 8; v++) begin
      reframe_en = VEC[v][13];
      bypass_mode = VEC[v][12];
      s0 = n_strobe;
      for (int i = 9; i >= 0; i--) begin
        send_bit(VEC[v][i]);
        if (i == 5) idle(2);
      end
      bit_valid = 1'b0;
      chk("R4", "one strobe per 10 bits across gap", n_strobe - s0, 1);
      chk("R3", "sym_valid", sym_valid, 1);
      chk("R3", "sym_data", sym_data, VEC[v][9:0]);
      chk("R11", "sym_is_comma", sym_is_comma, VEC[v][11]);
      chk(VEC[v][12] ? "R9" : "R8", "rdy_pulse", rdy_pulse, VEC[v][10]);
      chk("R2", "framed", frame_pending, 0);
      idle(1);
    end

    // R5: disarmed, comma at offset 3 ignored, boundary held
    reframe_en = 1'b0;
    bypass_mode = 1'b0;
    s0 = n_strobe;
    for (int i = 19; i >= 0; i--) begin
      send_bit(SKEW[i]);
      if (i == 10) begin
        chk("R5", "held boundary data", sym_data, SKEW[19:10]);
        chk("R5", "held boundary comma flag", sym_is_comma, 0);
      end
      if (i == 7) chk("R5", "no strobe on skewed comma", sym_valid, 0);
      if (i == 0) chk("R5", "second held symbol", sym_data, SKEW[9:0]);
    end
    idle(1);
    chk("R5", "strobe count", n_strobe - s0, 2);

    // R7: armed, same stream realigns on the comma at offset 3
    reframe_en = 1'b1;
    s0 = n_strobe;
    for (int i = 19; i >= 0; i--) begin
      send_bit(SKEW[i]);
      if (i == 10) chk("R7", "old boundary symbol", sym_data, SKEW[19:10]);
      if (i == 7) begin
        chk("R7", "realign strobe", sym_valid, 1);
        chk("R7", "realign data", sym_data, KN);
        chk("R11", "realign comma flag", sym_is_comma, 1);
        chk("R8", "realign rdy", rdy_pulse, 1);
      end
    end
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    chk("R7", "symbol after realign", sym_data, {SKEW[6:0], 3'b101});
    chk("R7", "symbol after realign valid", sym_valid, 1);
    idle(1);
    chk("R7", "strobe count", n_strobe - s0, 3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule